// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each accepted request names an operation. It supplies a destination operand and a second operand, which is either a register value or an immediate. The block returns a registered 8-bit result one cycle later. It also keeps the processor's six status flags:

- carry
- zero
- negative
- two's-complement overflow
- sign
- half carry

Each operation rewrites only the flags that belong to it. The others keep their earlier values. The stored carry feeds the carry-chained add and subtract operations.

A word operation adds or subtracts a small unsigned immediate to or from a 16-bit register pair. It takes two cycles. The low byte goes through the 8-bit adder in the first cycle. The high byte goes through it in the second cycle, together with the carry or borrow from the first. While a word operation is in flight, the unit reports busy and ignores new requests.

Top module: `byte_alu_core`

## Requirements
- R1: Operation codes on `op_sel` are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 negate, 5 and, 6 or, 7 exclusive or, 8 clear bits (`opd` AND NOT `opr`), 9 ones' complement, 10 increment, 11 decrement, 12 test (pass `opd`), 13 clear, 14 set to all ones, 15 word add, 16 word subtract. A request is accepted when `op_valid` is high and `busy` is low. A byte operation (codes 0 to 14) accepted on a clock edge shows its result on `res_lo` after that edge, pulses `done` high for exactly that cycle, and drives `res_hi` to 0.
- R2: `flags` bit positions are 0 carry, 1 zero, 2 negative, 3 overflow, 4 sign, 5 half carry. Add, add with carry, subtract, subtract with borrow and negate rewrite all six flags. Zero is set when the result is 0, negative is result bit 7, and sign is negative XOR overflow.
- R3: For addition, carry is the carry out of bit 7 and half carry is the carry out of bit 3. For subtraction, carry is the borrow out of bit 7 and half carry is the borrow into bit 4. Overflow is signed overflow of the 8-bit operation.
- R4: Add with carry adds the stored carry flag to the sum. Subtract with borrow also subtracts the stored carry flag.
- R5: And, or, exclusive or, clear bits, test and clear rewrite zero, negative, overflow (always 0) and sign. Carry and half carry keep their values.
- R6: Increment and decrement wrap modulo 256 and rewrite zero, negative, overflow and sign, leaving carry and half carry unchanged. Overflow is set only for 0x7F to 0x80 on increment and 0x80 to 0x7F on decrement.
- R7: Ones' complement returns 0xFF minus `opd`, sets carry to 1 and clears overflow, leaving half carry unchanged. Negate returns 0 minus `opd`, with carry set exactly when the result is nonzero.
- R8: Set to all ones returns 0xFF and changes no flag.
- R9: A word operation uses `{opd_hi, opd}` as the pair and `opr[5:0]` as an unsigned immediate; `opr[7:6]` are ignored. `busy` is high for the cycle after acceptance. `done` pulses on the following cycle with the 16-bit result on `{res_hi, res_lo}`. Carry, zero, negative, overflow and sign then describe the 16-bit result and half carry is unchanged.
- R10: A request presented while `busy` is high is ignored and does not disturb the word operation in flight.
- R11: Codes 17 to 31 are ignored: no `done` pulse, and the results and flags keep their values.
- R12: After reset, `busy`, `done`, `res_lo`, `res_hi` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 5 | Operation code |
| opd | input | 8 | Destination operand, or low byte of the pair |
| opr | input | 8 | Second operand or immediate |
| opd_hi | input | 8 | High byte of the pair for word operations |
| busy | output | 1 | Word operation in its second cycle |
| done | output | 1 | Result and flags updated this cycle |
| res_lo | output | 8 | Result, or low byte of the word result |
| res_hi | output | 8 | High byte of the word result, 0 after byte operations |
| flags | output | 6 | Status flags, positions as in R2 |

## Verification
The hardest state to reach is an add with carry or a subtract with borrow that runs with a chosen carry flag. The block has no way to load a flag directly. Before each such vector, the bench therefore issues a ones' complement to force carry to 1, or a subtraction of zero from zero to force it to 0. Each operand pair is then swept with both carry values. The other hard case is the word operation with an intruding request during its busy cycle. The bench keeps `op_valid` high through that cycle with a different operation on the inputs. The bench then expects the 16-bit result exactly as if the intruder were absent.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

   localparam int OP_W  = 5;
   localparam int NFLAG = 6;

   localparam logic [OP_W-1:0] OP_ADD  = 5'd0;
   localparam logic [OP_W-1:0] OP_ADC  = 5'd1;
   localparam logic [OP_W-1:0] OP_SUB  = 5'd2;
   localparam logic [OP_W-1:0] OP_SBC  = 5'd3;
   localparam logic [OP_W-1:0] OP_NEG  = 5'd4;
   localparam logic [OP_W-1:0] OP_AND  = 5'd5;
   localparam logic [OP_W-1:0] OP_OR   = 5'd6;
   localparam logic [OP_W-1:0] OP_EOR  = 5'd7;
   localparam logic [OP_W-1:0] OP_CLRB = 5'd8;
   localparam logic [OP_W-1:0] OP_COM  = 5'd9;
   localparam logic [OP_W-1:0] OP_INC  = 5'd10;
   localparam logic [OP_W-1:0] OP_DEC  = 5'd11;
   localparam logic [OP_W-1:0] OP_TST  = 5'd12;
   localparam logic [OP_W-1:0] OP_ZERO = 5'd13;
   localparam logic [OP_W-1:0] OP_ONES = 5'd14;
   localparam logic [OP_W-1:0] OP_WADD = 5'd15;
   localparam logic [OP_W-1:0] OP_WSUB = 5'd16;
   localparam logic [OP_W-1:0] OP_LAST = OP_WSUB;

   // bit 0 is carry, bit 5 is half carry
   typedef struct packed {
      logic h;
      logic s;
      logic v;
      logic n;
      logic z;
      logic c;
   } alu_flags_t;

   function automatic logic op_defined(input logic [OP_W-1:0] op);
      return op <= OP_LAST;
   endfunction

   function automatic logic op_is_word(input logic [OP_W-1:0] op);
      return (op == OP_WADD) || (op == OP_WSUB);
   endfunction

   function automatic logic op_is_logic(input logic [OP_W-1:0] op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_EOR) ||
             (op == OP_CLRB) || (op == OP_TST) || (op == OP_ZERO);
   endfunction

   function automatic logic op_uses_adder(input logic [OP_W-1:0] op);
      return (op <= OP_NEG) || (op == OP_INC) || (op == OP_DEC) ||
             op_is_word(op);
   endfunction

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] y,
   output logic         cy,
   output logic         hc,
   output logic         ovf
);
   localparam int HB = W / 2;

   logic [W-1:0] bx;
   logic         ci;
   logic         raw_c;
   logic         raw_h;

   // subtraction as a + ~b + ~borrow_in; carries flip to borrows
   assign bx = sub ? ~b : b;
   assign ci = sub ? ~cin : cin;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] ch;
         assign ch[0] = ci;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign y[i]    = a[i] ^ bx[i] ^ ch[i];
            assign ch[i+1] = (a[i] & bx[i]) | (ch[i] & (a[i] ^ bx[i]));
         end
         assign raw_c = ch[W];
         assign raw_h = ch[HB];
         assign ovf   = ch[W] ^ ch[W-1];
      end else begin : g_split
         logic [HB:0]   lo_sum;
         logic [W-HB:0] hi_sum;
         assign lo_sum = {1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, ci};
         assign hi_sum = {1'b0, a[W-1:HB]} + {1'b0, bx[W-1:HB]} + {{(W-HB){1'b0}}, lo_sum[HB]};
         assign y      = {hi_sum[W-HB-1:0], lo_sum[HB-1:0]};
         assign raw_c  = hi_sum[W-HB];
         assign raw_h  = lo_sum[HB];
         assign ovf    = (a[W-1] == bx[W-1]) && (y[W-1] != a[W-1]);
      end
   endgenerate

   assign cy = raw_c ^ sub;
   assign hc = raw_h ^ sub;

endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic import byte_alu_pkg::*; #(
   parameter int W = 8
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   output logic [W-1:0]    y
);
   always_comb begin
      case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_EOR:  y = a ^ b;
         OP_CLRB: y = a & ~b;
         OP_COM:  y = ~a;
         OP_TST:  y = a;
         OP_ZERO: y = '0;
         OP_ONES: y = '1;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/byte_alu_flagmerge.sv
module byte_alu_flagmerge import byte_alu_pkg::*; (
   input  alu_flags_t held,
   input  alu_flags_t fresh,
   input  alu_flags_t upd,
   output alu_flags_t merged
);
   logic [NFLAG-1:0] hv;
   logic [NFLAG-1:0] fv;
   logic [NFLAG-1:0] uv;
   logic [NFLAG-1:0] mv;

   assign hv = held;
   assign fv = fresh;
   assign uv = upd;

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         assign mv[i] = uv[i] ? fv[i] : hv[i];
      end
   endgenerate

   assign merged = mv;
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core import byte_alu_pkg::*; #(
   parameter int DATA_W       = 8,
   parameter int IMM_W        = 6,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] opd,
   input  logic [DATA_W-1:0] opr,
   input  logic [DATA_W-1:0] opd_hi,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] res_lo,
   output logic [DATA_W-1:0] res_hi,
   output logic [NFLAG-1:0]  flags
);
   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("byte_alu_core: DATA_W must be even and at least 4");
      end
      if (IMM_W < 1 || IMM_W >= DATA_W) begin : g_bad_imm
         $error("byte_alu_core: IMM_W must lie between 1 and DATA_W-1");
      end
   endgenerate

   // state
   logic              phase_hi_q;
   logic              wsub_q;
   logic              wcarry_q;
   logic [DATA_W-1:0] pair_hi_q;
   logic [DATA_W-1:0] lo_part_q;
   logic              done_q;
   logic [DATA_W-1:0] res_lo_q;
   logic [DATA_W-1:0] res_hi_q;
   alu_flags_t        flags_q;

   logic accept;
   logic word_start;
   assign accept     = op_valid && !phase_hi_q && op_defined(op_sel);
   assign word_start = accept && op_is_word(op_sel);

   // adder operand steering
   logic [DATA_W-1:0] add_a;
   logic [DATA_W-1:0] add_b;
   logic              add_sub;
   logic              add_cin;
   logic [DATA_W-1:0] imm_ext;

   assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, opr[IMM_W-1:0]};

   always_comb begin
      add_a   = opd;
      add_b   = opr;
      add_sub = 1'b0;
      add_cin = 1'b0;
      if (phase_hi_q) begin
         add_a   = pair_hi_q;
         add_b   = '0;
         add_sub = wsub_q;
         add_cin = wcarry_q;
      end else begin
         case (op_sel)
            OP_ADC:  add_cin = flags_q.c;
            OP_SUB:  add_sub = 1'b1;
            OP_SBC: begin
               add_sub = 1'b1;
               add_cin = flags_q.c;
            end
            OP_NEG: begin
               add_a   = '0;
               add_b   = opd;
               add_sub = 1'b1;
            end
            OP_INC:  add_b = ONE;
            OP_DEC: begin
               add_b   = ONE;
               add_sub = 1'b1;
            end
            OP_WADD: add_b = imm_ext;
            OP_WSUB: begin
               add_b   = imm_ext;
               add_sub = 1'b1;
            end
            default: ;
         endcase
      end
   end

   logic [DATA_W-1:0] sum;
   logic              sum_cy;
   logic              sum_hc;
   logic              sum_ovf;

   byte_alu_addsub #(
      .W      (DATA_W),
      .RIPPLE (RIPPLE_ADDER)
   ) u_addsub (
      .a   (add_a),
      .b   (add_b),
      .sub (add_sub),
      .cin (add_cin),
      .y   (sum),
      .cy  (sum_cy),
      .hc  (sum_hc),
      .ovf (sum_ovf)
   );

   logic [DATA_W-1:0] lgc_y;

   byte_alu_logic #(
      .W (DATA_W)
   ) u_logic (
      .op (op_sel),
      .a  (opd),
      .b  (opr),
      .y  (lgc_y)
   );

   // result and candidate flags
   logic [DATA_W-1:0] byte_res;
   alu_flags_t        cand;
   alu_flags_t        upd;
   alu_flags_t        merged;

   assign byte_res = (phase_hi_q || op_uses_adder(op_sel)) ? sum : lgc_y;

   always_comb begin
      cand.c = sum_cy;
      cand.h = sum_hc;
      cand.v = sum_ovf;
      cand.n = byte_res[MSB];
      cand.z = (byte_res == '0);
      upd    = '0;
      if (phase_hi_q) begin
         cand.z = (sum == '0) && (lo_part_q == '0);
         upd.c  = 1'b1;
         upd.z  = 1'b1;
         upd.n  = 1'b1;
         upd.v  = 1'b1;
         upd.s  = 1'b1;
      end else if (op_sel <= OP_NEG) begin
         upd = '1;
      end else if (op_sel == OP_COM) begin
         cand.c = 1'b1;
         cand.v = 1'b0;
         upd.c  = 1'b1;
         upd.z  = 1'b1;
         upd.n  = 1'b1;
         upd.v  = 1'b1;
         upd.s  = 1'b1;
      end else if (op_sel == OP_INC || op_sel == OP_DEC) begin
         upd.z = 1'b1;
         upd.n = 1'b1;
         upd.v = 1'b1;
         upd.s = 1'b1;
      end else if (op_is_logic(op_sel)) begin
         cand.v = 1'b0;
         upd.z  = 1'b1;
         upd.n  = 1'b1;
         upd.v  = 1'b1;
         upd.s  = 1'b1;
      end
      cand.s = cand.n ^ cand.v;
   end

   byte_alu_flagmerge u_merge (
      .held   (flags_q),
      .fresh  (cand),
      .upd    (upd),
      .merged (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_hi_q <= 1'b0;
         wsub_q     <= 1'b0;
         wcarry_q   <= 1'b0;
         pair_hi_q  <= '0;
         lo_part_q  <= '0;
         done_q     <= 1'b0;
         res_lo_q   <= '0;
         res_hi_q   <= '0;
         flags_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (phase_hi_q) begin
            phase_hi_q <= 1'b0;
            res_lo_q   <= lo_part_q;
            res_hi_q   <= sum;
            flags_q    <= merged;
            done_q     <= 1'b1;
         end else if (word_start) begin
            phase_hi_q <= 1'b1;
            wsub_q     <= add_sub;
            wcarry_q   <= sum_cy;
            pair_hi_q  <= opd_hi;
            lo_part_q  <= sum;
         end else if (accept) begin
            res_lo_q <= byte_res;
            res_hi_q <= '0;
            flags_q  <= merged;
            done_q   <= 1'b1;
         end
      end
   end

   assign busy   = phase_hi_q;
   assign done   = done_q;
   assign res_lo = res_lo_q;
   assign res_hi = res_hi_q;
   assign flags  = flags_q;

endmodule

// File: rtl/byte_alu_core_chk.sv
module byte_alu_core_chk import byte_alu_pkg::*; (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [OP_W-1:0]  op_sel,
   input logic             busy,
   input logic             done,
   input logic [NFLAG-1:0] flags
);
   logic acc;
   assign acc = op_valid && !busy;

   a_r1_byte_done: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op_defined(op_sel) && !op_is_word(op_sel)) |=> (done && !busy));

   a_r9_word_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op_is_word(op_sel)) |=> (busy && !done));

   a_r9_word_finish: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (done && !busy));

   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_valid) |=> !busy);

   a_r8_ones_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op_sel == OP_ONES) |=> $stable(flags));

   a_r5_logic_keeps_ch: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op_is_logic(op_sel)) |=> (flags[0] == $past(flags[0]) && flags[5] == $past(flags[5])));

   a_r7_com_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op_sel == OP_COM) |=> (flags[0] && !flags[3]));

   a_r11_undefined_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !op_defined(op_sel)) |=> (!done && $stable(flags)));

endmodule

bind byte_alu_core byte_alu_core_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_sel   (op_sel),
   .busy     (busy),
   .done     (done),
   .flags    (flags)
);

// File: tb/byte_alu_core_bench.sv
module byte_alu_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_sel = '0;
   logic [7:0] opd = '0;
   logic [7:0] opr = '0;
   logic [7:0] opd_hi = '0;
   logic       busy;
   logic       done;
   logic [7:0] res_lo;
   logic [7:0] res_hi;
   logic [5:0] flags;

   int n_vec = 0;
   int n_bad = 0;

   logic [5:0] mflags = '0;
   logic [7:0] m_lo = '0;
   logic [7:0] m_hi = '0;

   always #4 clk = ~clk;

   byte_alu_core u_byte_alu_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_sel   (op_sel),
      .opd      (opd),
      .opr      (opr),
      .opd_hi   (opd_hi),
      .busy     (busy),
      .done     (done),
      .res_lo   (res_lo),
      .res_hi   (res_hi),
      .flags    (flags)
   );

   task automatic cmp(input string tag, input logic [23:0] act, input logic [23:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (busy,done,hi,lo,flags)", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input int op);
      case (op)
         0:              return "R1 R2 R3";
         1, 3:           return "R1 R4";
         2:              return "R1 R3";
         4, 9:           return "R1 R7";
         10, 11:         return "R1 R6";
         14:             return "R1 R8";
         15, 16:         return "R9 R10";
         5, 6, 7, 8, 12, 13: return "R1 R5";
         default:        return "R11";
      endcase
   endfunction

   function automatic int bval(input int i);
      case (i)
         0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h0F;
         4: return 8'h10;  5: return 8'h3F;  6: return 8'h40;  7: return 8'h7E;
         8: return 8'h7F;  9: return 8'h80;  10: return 8'h81; 11: return 8'hC0;
         12: return 8'hEF; 13: return 8'hF0; 14: return 8'hFE; default: return 8'hFF;
      endcase
   endfunction

   // reference model, arithmetic on integers
   task automatic model_op(input int op, input int a, input int b, input int hi);
      int r, cin, c, z, n, v, h, upd_c, upd_h, upd_f, p, kk;
      cin = mflags[0]; c = mflags[0]; v = mflags[3]; h = mflags[5];
      upd_c = 0; upd_h = 0; upd_f = 1; r = 0;
      if (op > 16) return;
      case (op)
         0, 1: begin
            if (op == 0) cin = 0;
            r = a + b + cin;
            c = (r > 255); h = (((a & 15) + (b & 15) + cin) > 15);
            r = r & 255; v = (((a ^ r) & (b ^ r) & 128) != 0);
            upd_c = 1; upd_h = 1;
         end
         2, 3, 4: begin
            if (op == 2) cin = 0;
            if (op == 4) begin cin = 0; b = a; a = 0; end
            r = a - b - cin;
            c = (r < 0); h = (((a & 15) - (b & 15) - cin) < 0);
            r = r & 255; v = (((a ^ b) & (a ^ r) & 128) != 0);
            upd_c = 1; upd_h = 1;
         end
         5:  begin r = a & b; v = 0; end
         6:  begin r = a | b; v = 0; end
         7:  begin r = a ^ b; v = 0; end
         8:  begin r = a & (255 - b); v = 0; end
         9:  begin r = 255 - a; v = 0; c = 1; upd_c = 1; end
         10: begin r = (a + 1) & 255; v = (a == 127); end
         11: begin r = (a - 1) & 255; v = (a == 128); end
         12: begin r = a; v = 0; end
         13: begin r = 0; v = 0; end
         14: begin r = 255; upd_f = 0; end
         default: ;
      endcase
      if (op >= 15) begin
         p = hi * 256 + a; kk = b & 63;
         if (op == 15) begin
            r = p + kk; c = (r > 65535); r = r & 65535;
            v = (hi < 128) && (r >= 32768);
         end else begin
            r = p - kk; c = (r < 0); r = r & 65535;
            v = (hi >= 128) && (r < 32768);
         end
         z = (r == 0); n = (r >> 15) & 1;
         mflags = {h[0], n[0] ^ v[0], v[0], n[0], z[0], c[0]};
         m_lo = r[7:0]; m_hi = r[15:8];
      end else begin
         z = (r == 0); n = (r >> 7) & 1;
         if (upd_f != 0) begin
            if (upd_c == 0) c = mflags[0];
            if (upd_h == 0) h = mflags[5];
            mflags = {h[0], n[0] ^ v[0], v[0], n[0], z[0], c[0]};
         end
         m_lo = r[7:0]; m_hi = 8'h00;
      end
   endtask

   // called at a falling edge; returns at the falling edge where the result is sampled
   task automatic apply(input int op, input int a, input int b, input int hi);
      logic exp_done;
      op_valid = 1'b1; op_sel = op[4:0]; opd = a[7:0]; opr = b[7:0]; opd_hi = hi[7:0];
      @(negedge clk);
      if (op == 15 || op == 16) begin
         cmp("R9 busy cycle", {busy, done, 22'h0}, {1'b1, 1'b0, 22'h0});
         op_sel = 5'd0; opd = ~a[7:0]; opr = 8'h5A; opd_hi = 8'hA5; // R10 intruder
         @(negedge clk);
      end
      exp_done = (op <= 16);
      model_op(op, a, b, hi);
      cmp(tag_of(op), {busy, done, res_hi, res_lo, flags}, {1'b0, exp_done, m_hi, m_lo, mflags});
   endtask

   initial begin : watchdog
      repeat (180000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R12 reset", {busy, done, res_hi, res_lo, flags}, 24'h0);

      for (int op = 0; op <= 14; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 16; bi++) begin
               if (op == 1 || op == 3) begin
                  for (int ci = 0; ci < 2; ci++) begin
                     if (ci == 1) apply(9, 0, 0, 0); // R4 preset carry=1
                     else         apply(2, 0, 0, 0); // R4 preset carry=0
                     apply(op, a, bval(bi), 0);
                  end
               end else begin
                  apply(op, a, bval(bi), 0);
               end
            end
         end
      end

      // R9 word sweep, upper immediate bits set on some vectors
      for (int op = 15; op <= 16; op++) begin
         for (int hi = 0; hi < 4; hi++) begin
            for (int lo = 0; lo < 4; lo++) begin
               for (int k = 0; k < 64; k++) begin
                  apply(op, (lo == 0) ? 0 : (lo == 1) ? 8'h3F : (lo == 2) ? 8'hC0 : 8'hFF,
                        k | (((k % 3) == 0) ? 8'hC0 : 0),
                        (hi == 0) ? 0 : (hi == 1) ? 8'h7F : (hi == 2) ? 8'h80 : 8'hFF);
               end
            end
         end
      end

      // R11 undefined codes after flags are in a known nonzero state
      apply(2, 8'h10, 8'h01, 0);
      for (int op = 17; op < 32; op++) begin
         apply(op, 8'h33, 8'h44, 8'h55);
      end

      op_valid = 1'b0;
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule